// File: doc/BRIEF.md
# Width-Configurable Sample Byte Packer

This block converts between whole audio samples and the byte stream held in two byte-wide queues of 64 entries each. On the register side, a 32-bit write is split into byte lanes and appended to the transmit queue, lowest lane first. A read takes byte lanes from the receive queue and joins them into one sample. The number of lanes per sample follows a programmable bit length.

On the streaming side, a sink asks for a number of samples and receives one whole sample per clock from the transmit queue. A source is asked for a number of samples and gives one per clock into the receive queue. When a queue runs dry or fills up before a request is finished, the request ends and a one-cycle event pulse is raised. A status word gives both queue levels in samples, together with a full flag, a not-full flag and a busy flag.

Top module: `sample_lane_packer`

## Requirements
- R1: The sample width is `len_val + 1` bits, loaded by `len_we`. After reset the width is 8 bits. The lane count is the width divided by 8 and rounded up, capped at 4 (len_val 0..7 gives 1 lane, 8..15 gives 2, 16..23 gives 3, 24 and above gives 4).
- R2: A write with `enable` high appends lane 0 (bits [7:0]), then lane 1, lane 2 and lane 3 as the lane count allows. A lane is dropped if the transmit queue already holds 64 bytes at that point, and all later lanes of the same write are dropped as well.
- R3: A read joins lanes little-endian from the receive queue in the same cycle as `rd_en` and removes them at the next edge. Only bytes that are present are taken, and a lane that is missing reads as zero.
- R4: Writes have no effect while `enable` is low. `rd_data` is zero and no byte is removed unless both `enable` and `rx_en` are high.
- R5: `stat_word` bit 0 is high when the receive queue holds 64 bytes, bit 1 is high while the transmit queue holds fewer than 64 bytes, and bit 2 mirrors `busy`. Bits [8:4] give the receive level and bits [16:12] the transmit level. A level is bytes divided by the lane count, rounded down and saturated at 31. All other bits are zero.
- R6: A sink request is accepted only while `enable`, `tx_en` and `dout_en` are all high. It then gives one sample per cycle with `snk_valid`, for at most `snk_num` samples, each joined like R3.
- R7: If the transmit queue is empty while a sink request still has samples left, `tx_underrun` pulses for one cycle instead of `snk_valid`, and the request ends.
- R8: A source request is accepted while `enable` and `rx_en` are high. For each `src_take` cycle, the lanes of `src_sample` are appended as in R2. If the receive queue is full while samples remain, `rx_overrun` pulses for one cycle and the request ends.
- R9: `busy` is high exactly while a sink or source request is in progress.
- R10: A new request to an engine that is already in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| len_we | input | 1 | Load the sample length |
| len_val | input | 6 | Sample width minus one |
| enable | input | 1 | Block enable |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| dout_en | input | 1 | Transmit data output enable |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | 32 | Sample to append |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | 32 | Joined sample, valid while rd_en is high |
| stat_word | output | 32 | Levels and flags |
| snk_req | input | 1 | Sink request pulse |
| snk_num | input | 5 | Samples the sink requests |
| snk_valid | output | 1 | Sample delivered this cycle |
| snk_sample | output | 32 | Delivered sample |
| src_req | input | 1 | Source request pulse |
| src_num | input | 5 | Samples to fetch from the source |
| src_sample | input | 32 | Sample offered by the source |
| src_take | output | 1 | Source sample taken this cycle |
| tx_underrun | output | 1 | Transmit underrun event |
| rx_overrun | output | 1 | Receive overrun event |
| busy | output | 1 | A streaming request is in progress |

## Verification
On every cycle, the assertions check the following: queue occupancy never passes 64 bytes, an underrun or overrun pulse occurs only at an empty or full queue and never in a data cycle, delivered samples appear only under the three enables and while busy, and disabled writes and reads change nothing. Lane packing, little-endian byte order across mixed widths, level rounding and saturation, partial trailing samples, and the counts of delivered samples against requests can only be shown by the bench scenarios. The bench compares these against its own byte-queue model.

// File: rtl/slp_pkg.sv
package slp_pkg;
   // lanes needed for a sample of (len_m1 + 1) bits, capped at max_l
   function automatic int unsigned lanes_for(input int unsigned len_m1,
                                             input int unsigned max_l);
      int unsigned n;
      n = len_m1 / 8 + 1;
      return (n > max_l) ? max_l : n;
   endfunction
endpackage

// File: rtl/slp_byte_fifo.sv
module slp_byte_fifo #(
   parameter int unsigned DEPTH = 64,
   parameter int unsigned LANES = 4,
   localparam int unsigned PW = $clog2(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1),
   localparam int unsigned NW = $clog2(LANES + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NW-1:0]        push_req,
   input  logic [LANES*8-1:0]   push_data,
   input  logic [NW-1:0]        pop_req,
   output logic [LANES*8-1:0]   pop_data,
   output logic [CW-1:0]        count
);
   logic [7:0]    mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] cnt, space, preq, qreq, pgnt, qgnt;

   always_comb begin
      space = CW'(DEPTH) - cnt;
      preq  = CW'(push_req);
      qreq  = CW'(pop_req);
      pgnt  = (preq > space) ? space : preq;
      qgnt  = (qreq > cnt) ? cnt : qreq;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         wr_ptr <= wr_ptr + PW'(pgnt);
         rd_ptr <= rd_ptr + PW'(qgnt);
         cnt    <= cnt + pgnt - qgnt;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < int'(LANES); i++) begin
         if (CW'(i) < pgnt) mem[wr_ptr + PW'(i)] <= push_data[8*i +: 8];
      end
   end

   for (genvar g = 0; g < int'(LANES); g++) begin : g_lane
      assign pop_data[8*g +: 8] = (CW'(g) < qgnt) ? mem[rd_ptr + PW'(g)] : 8'h00;
   end

   assign count = cnt;
endmodule

// File: rtl/slp_stream_seq.sv
module slp_stream_seq #(
   parameter int unsigned NUM_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             allow,
   input  logic             go,
   input  logic [NUM_W-1:0] num,
   input  logic             blocked,
   output logic             active,
   output logic             step,
   output logic             fault
);
   logic [NUM_W-1:0] left;

   assign active = (left != '0);
   assign step   = active && allow && !blocked;
   assign fault  = active && allow && blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                left <= '0;
      else if (!active) begin
         if (go && allow)        left <= num;
      end else if (!allow || blocked) left <= '0;
      else                       left <= left - 1'b1;
   end
endmodule

// File: rtl/sample_lane_packer.sv
module sample_lane_packer #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned FIFO_BYTES = 64,
   parameter int unsigned LEN_W      = 6,
   parameter int unsigned NUM_W      = 5,
   parameter bit          LVL_SAT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              len_we,
   input  logic [LEN_W-1:0]  len_val,
   input  logic              enable,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              dout_en,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [31:0]       stat_word,
   input  logic              snk_req,
   input  logic [NUM_W-1:0]  snk_num,
   output logic              snk_valid,
   output logic [DATA_W-1:0] snk_sample,
   input  logic              src_req,
   input  logic [NUM_W-1:0]  src_num,
   input  logic [DATA_W-1:0] src_sample,
   output logic              src_take,
   output logic              tx_underrun,
   output logic              rx_overrun,
   output logic              busy
);
   localparam int unsigned LANES = DATA_W / 8;
   localparam int unsigned CW    = $clog2(FIFO_BYTES + 1);
   localparam int unsigned NW    = $clog2(LANES + 1);
   localparam int unsigned LVW   = 5;

   if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_bad_w
      $error("DATA_W must be a nonzero multiple of 8");
   end
   if ((FIFO_BYTES & (FIFO_BYTES - 1)) != 0 || FIFO_BYTES < LANES) begin : g_bad_d
      $error("FIFO_BYTES must be a power of two and hold one sample");
   end

   logic [LEN_W-1:0] len_q;
   logic [NW-1:0]    nb;
   logic [CW-1:0]    tx_cnt, rx_cnt;
   logic [DATA_W-1:0] tx_pop_data, rx_pop_data;
   logic             tx_act, rx_act, tx_step, rx_step;
   logic             rd_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      len_q <= LEN_W'(7);
      else if (len_we) len_q <= len_val;
   end

   assign nb    = NW'(slp_pkg::lanes_for(32'(len_q), LANES));
   assign rd_ok = enable && rx_en;

   slp_byte_fifo #(.DEPTH(FIFO_BYTES), .LANES(LANES)) u_txq (
      .clk(clk), .rst_n(rst_n),
      .push_req((wr_en && enable) ? nb : '0), .push_data(wr_data),
      .pop_req(tx_step ? nb : '0), .pop_data(tx_pop_data),
      .count(tx_cnt));

   slp_byte_fifo #(.DEPTH(FIFO_BYTES), .LANES(LANES)) u_rxq (
      .clk(clk), .rst_n(rst_n),
      .push_req(rx_step ? nb : '0), .push_data(src_sample),
      .pop_req((rd_en && rd_ok) ? nb : '0), .pop_data(rx_pop_data),
      .count(rx_cnt));

   slp_stream_seq #(.NUM_W(NUM_W)) u_tx_seq (
      .clk(clk), .rst_n(rst_n),
      .allow(enable && tx_en && dout_en), .go(snk_req), .num(snk_num),
      .blocked(tx_cnt == '0),
      .active(tx_act), .step(tx_step), .fault(tx_underrun));

   slp_stream_seq #(.NUM_W(NUM_W)) u_rx_seq (
      .clk(clk), .rst_n(rst_n),
      .allow(rd_ok), .go(src_req), .num(src_num),
      .blocked(rx_cnt == CW'(FIFO_BYTES)),
      .active(rx_act), .step(rx_step), .fault(rx_overrun));

   assign rd_data    = rd_ok ? rx_pop_data : '0;
   assign snk_valid  = tx_step;
   assign snk_sample = tx_pop_data;
   assign src_take   = rx_step;
   assign busy       = tx_act || rx_act;

   // sample levels: variant picks saturation or plain truncation
   logic [CW-1:0]  tx_div, rx_div;
   logic [LVW-1:0] tx_lvl, rx_lvl;
   assign tx_div = tx_cnt / CW'(nb);
   assign rx_div = rx_cnt / CW'(nb);

   if (LVL_SAT) begin : g_sat
      localparam logic [CW-1:0] LMAX = CW'((1 << LVW) - 1);
      assign tx_lvl = (tx_div > LMAX) ? LVW'(LMAX) : LVW'(tx_div);
      assign rx_lvl = (rx_div > LMAX) ? LVW'(LMAX) : LVW'(rx_div);
   end else begin : g_wrap
      assign tx_lvl = LVW'(tx_div);
      assign rx_lvl = LVW'(rx_div);
   end

   always_comb begin
      stat_word        = '0;
      stat_word[0]     = (rx_cnt == CW'(FIFO_BYTES));
      stat_word[1]     = (tx_cnt != CW'(FIFO_BYTES));
      stat_word[2]     = busy;
      stat_word[8:4]   = rx_lvl;
      stat_word[16:12] = tx_lvl;
   end
endmodule

// File: rtl/sample_lane_packer_chk.sv
module sample_lane_packer_chk #(
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned DATA_W = 32,
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              tx_en,
   input logic              rx_en,
   input logic              dout_en,
   input logic              wr_en,
   input logic [DATA_W-1:0] rd_data,
   input logic              snk_valid,
   input logic              src_take,
   input logic              busy,
   input logic              tx_underrun,
   input logic              rx_overrun,
   input logic [CW-1:0]     tx_cnt,
   input logic [CW-1:0]     rx_cnt
);
   p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_cnt <= CW'(DEPTH)) && (rx_cnt <= CW'(DEPTH)));

   p_rd_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(enable && rx_en) |-> (rd_data == '0));

   p_wr_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !enable && !snk_valid) |=> (tx_cnt == $past(tx_cnt)));

   p_valid_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      snk_valid |-> (enable && tx_en && dout_en));

   p_underrun_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |-> (tx_cnt == '0) && !snk_valid);

   p_underrun_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_underrun |=> !snk_valid && !tx_underrun);

   p_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_overrun |-> (rx_cnt == CW'(DEPTH)) && !src_take);

   p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (snk_valid || src_take) |-> busy);
endmodule

bind sample_lane_packer sample_lane_packer_chk #(.DEPTH(FIFO_BYTES), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .enable(enable), .tx_en(tx_en), .rx_en(rx_en),
   .dout_en(dout_en), .wr_en(wr_en), .rd_data(rd_data), .snk_valid(snk_valid),
   .src_take(src_take), .busy(busy), .tx_underrun(tx_underrun),
   .rx_overrun(rx_overrun), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt));

// File: tb/sample_lane_packer_tb.sv
module sample_lane_packer_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic        len_we = 0, enable = 0, tx_en = 0, rx_en = 0, dout_en = 0;
   logic [5:0]  len_val = '0;
   logic        wr_en = 0, rd_en = 0, snk_req = 0, src_req = 0;
   logic [31:0] wr_data = '0, src_sample = '0;
   logic [4:0]  snk_num = '0, src_num = '0;
   logic [31:0] rd_data, stat_word, snk_sample;
   logic        snk_valid, src_take, tx_underrun, rx_overrun, busy;

   sample_lane_packer u_dut (
      .clk(clk), .rst_n(rst_n), .len_we(len_we), .len_val(len_val),
      .enable(enable), .tx_en(tx_en), .rx_en(rx_en), .dout_en(dout_en),
      .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
      .stat_word(stat_word), .snk_req(snk_req), .snk_num(snk_num),
      .snk_valid(snk_valid), .snk_sample(snk_sample), .src_req(src_req),
      .src_num(src_num), .src_sample(src_sample), .src_take(src_take),
      .tx_underrun(tx_underrun), .rx_overrun(rx_overrun), .busy(busy));

   int checks = 0, fails = 0;
   bit done = 0;
   int cur_nb = 1;
   byte unsigned txq[$], rxq[$];
   logic [31:0] last_snk;

   // {len_m1, write data, expected sample}
   localparam logic [69:0] VECS [0:5] = '{
      {6'd7,  32'hA1B2C3D4, 32'h000000D4},
      {6'd15, 32'h11223344, 32'h00003344},
      {6'd23, 32'hDEADBEEF, 32'h00ADBEEF},
      {6'd31, 32'hCAFEF00D, 32'hCAFEF00D},
      {6'd40, 32'h01234567, 32'h01234567},
      {6'd8,  32'h0000ABCD, 32'h0000ABCD}};

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic int nb_of(input int len);
      int n = len / 8 + 1;
      return (n > 4) ? 4 : n;
   endfunction

   function automatic logic [31:0] pop_tx();
      logic [31:0] v = '0;
      for (int i = 0; i < cur_nb; i++) if (txq.size() > 0) v[8*i +: 8] = txq.pop_front();
      return v;
   endfunction

   function automatic logic [31:0] pop_rx();
      logic [31:0] v = '0;
      for (int i = 0; i < cur_nb; i++) if (rxq.size() > 0) v[8*i +: 8] = rxq.pop_front();
      return v;
   endfunction

   task automatic set_len(input int v);
      @(negedge clk); len_we = 1; len_val = 6'(v);
      @(negedge clk); len_we = 0;
      cur_nb = nb_of(v);
   endtask

   task automatic wr(input logic [31:0] d);
      @(negedge clk); wr_en = 1; wr_data = d;
      if (enable) for (int i = 0; i < cur_nb; i++) if (txq.size() < 64) txq.push_back(d[8*i +: 8]);
      @(negedge clk); wr_en = 0;
   endtask

   task automatic rd_chk(input string tag, input bit use_exp, input logic [31:0] exp);
      logic [31:0] m;
      m = (enable && rx_en) ? pop_rx() : 32'h0;
      @(negedge clk); rd_en = 1;
      #1 chk(rd_data == (use_exp ? exp : m), tag, rd_data, use_exp ? exp : m);
      @(negedge clk); rd_en = 0;
   endtask

   task automatic run_snk(input int n, input bit dup, output int nval, output int nund);
      logic [31:0] e;
      bit bad = 0;
      @(negedge clk); snk_req = 1; snk_num = 5'(n);
      @(negedge clk); snk_req = 0;
      nval = 0; nund = 0;
      for (int k = 0; k < n + 3; k++) begin
         if (dup && k == 1) begin snk_req = 1; snk_num = 5'd5; end else snk_req = 0;
         #1;
         if (snk_valid) begin
            e = pop_tx(); nval++; last_snk = snk_sample;
            chk(snk_sample == e, "R6 sample", snk_sample, e);
            if (!busy) bad = 1;
         end
         if (tx_underrun) nund++;
         @(negedge clk);
      end
      snk_req = 0;
      #1 chk(!bad && !busy, "R9 busy during/after sink", {31'b0, busy}, 32'h0);
   endtask

   task automatic run_src(input int n, input logic [31:0] d, output int ntake, output int nov);
      @(negedge clk); src_req = 1; src_num = 5'(n); src_sample = d;
      @(negedge clk); src_req = 0;
      ntake = 0; nov = 0;
      for (int k = 0; k < n + 3; k++) begin
         #1;
         if (src_take) begin
            ntake++;
            for (int i = 0; i < cur_nb; i++) if (rxq.size() < 64) rxq.push_back(d[8*i +: 8]);
         end
         if (rx_overrun) nov++;
         @(negedge clk);
      end
   endtask

   initial begin : wdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog act=timeout exp=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      int nv, nu;
      repeat (3) @(negedge clk);
      #1 chk(stat_word == 32'h2, "R5 reset status", stat_word, 32'h2);
      chk(rd_data == 0 && busy == 0, "R4 reset outputs", rd_data, 0);
      @(negedge clk); rst_n = 1;
      enable = 1; tx_en = 1; rx_en = 1; dout_en = 1;

      // R1: default width of 8 bits gives one lane
      wr(32'h5A5A5A77);
      run_snk(1, 0, nv, nu);
      chk(last_snk == 32'h77 && nv == 1, "R1 default width", last_snk, 32'h77);

      // table walk: pack, stream out, stream in, read back
      for (int v = 0; v < 6; v++) begin
         set_len(int'(VECS[v][69:64]));
         wr(VECS[v][63:32]);
         #1 chk(stat_word[16:12] == 5'd1, "R2 tx level one", 32'(stat_word[16:12]), 1);
         run_snk(1, 0, nv, nu);
         chk(last_snk == VECS[v][31:0], "R6 table sink", last_snk, VECS[v][31:0]);
         run_src(1, VECS[v][63:32], nv, nu);
         chk(nv == 1, "R8 table take", nv, 1);
         rd_chk("R3 table read", 1, VECS[v][31:0]);
      end

      // R4: disabled write and guarded read
      set_len(7);
      enable = 0; wr(32'hFF); enable = 1;
      #1 chk(stat_word[16:12] == 0, "R4 disabled write", 32'(stat_word[16:12]), 0);
      run_src(1, 32'h42, nv, nu);
      rx_en = 0;
      rd_chk("R4 read gated", 1, 32'h0);
      rx_en = 1;
      #1 chk(stat_word[8:4] == 1, "R4 gated read kept byte", 32'(stat_word[8:4]), 1);
      rd_chk("R4 read after gate", 1, 32'h42);

      // R3/R5: partial trailing sample
      run_src(1, 32'h99, nv, nu);
      set_len(15);
      #1 chk(stat_word[8:4] == 0, "R5 partial level", 32'(stat_word[8:4]), 0);
      rd_chk("R3 missing lane zero", 1, 32'h0099);

      // R2/R5: fill with a split final write
      set_len(7); wr(32'hEE);
      set_len(31);
      for (int i = 0; i < 17; i++) wr(32'h10203040 + 32'(i));
      #1 chk(stat_word[16:12] == 16 && stat_word[1] == 0, "R2 full tx", stat_word, 32'h10000);
      chk(txq.size() == 64, "R2 model full", txq.size(), 64);
      set_len(7);
      #1 chk(stat_word[16:12] == 31, "R5 saturate", 32'(stat_word[16:12]), 31);
      set_len(23);
      #1 chk(stat_word[16:12] == 21, "R5 divide by three", 32'(stat_word[16:12]), 21);
      set_len(31);
      run_snk(16, 0, nv, nu);
      chk(nv == 16 && nu == 0, "R6 drain count", nv, 16);
      run_snk(1, 0, nv, nu);
      chk(nv == 0 && nu == 1, "R7 empty underrun", nu, 1);

      // R7: underrun part way through
      wr(32'h1); wr(32'h2);
      run_snk(4, 0, nv, nu);
      chk(nv == 2 && nu == 1, "R7 mid underrun", {nv[15:0], nu[15:0]}, 32'h00020001);

      // R10: second request during a transfer
      for (int i = 0; i < 5; i++) wr(32'hA0 + 32'(i));
      run_snk(3, 1, nv, nu);
      chk(nv == 3, "R10 repeat ignored", nv, 3);
      run_snk(2, 0, nv, nu);
      chk(nv == 2 && nu == 0, "R10 remainder", nv, 2);

      // R6: output enable gates the sink
      wr(32'h77);
      dout_en = 0;
      run_snk(1, 0, nv, nu);
      chk(nv == 0 && nu == 0, "R6 gated sink", nv, 0);
      dout_en = 1;
      run_snk(1, 0, nv, nu);
      chk(nv == 1 && last_snk == 32'h77, "R6 after ungate", last_snk, 32'h77);

      // R8: overrun
      run_src(17, 32'h55667788, nv, nu);
      chk(nv == 16 && nu == 1, "R8 overrun", {nv[15:0], nu[15:0]}, 32'h00100001);
      #1 chk(stat_word[0] == 1 && stat_word[8:4] == 16, "R5 rx full", stat_word, 32'h103);
      for (int i = 0; i < 16; i++) rd_chk("R3 drain rx", 0, 32'h0);
      #1 chk(stat_word[0] == 0 && stat_word[8:4] == 0, "R5 rx empty", stat_word, 32'h2);

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule